// File: doc/BRIEF.md
# Round-Robin Batch Distributor with Ordering Tokens

This block takes one ordered stream of work items and deals it out to a set of downstream queues. Each queue receives a whole batch of items before the next queue in the rotation is chosen. When a batch is closed, the block sends an extra token beat to the queue that received that batch. Parallel consumers can then put the results back into submission order by following the tokens: after reading a token from one queue, a consumer moves on to the next queue.

An item may occupy several beats. Every beat except the final one is marked as a continuation, and the batch counter advances only on the final beat. A multi-beat item is therefore never split across two queues. The batch size is an input that can be changed at run time. A flush request closes a partially filled batch early. The input and every output use valid/ready handshakes. All outputs share one data bus and one token flag, and a separate valid bit selects the queue that the current beat belongs to.

Top module: `rr_batch_dist`

## Requirements
- R1: After reset the unit pointer is 0 and the batch count is 0: no valid or token is shown while the input is idle, and the first item goes to queue 0.
- R2: A data beat is offered only to the queue under the pointer, with out_data equal to in_data and out_tok equal to 0, in the same cycle that it is presented.
- R3: When the item that completes a batch is accepted, the next cycle presents a token beat (out_tok=1, out_data=0) on that same queue, and in_ready stays 0 until the token is accepted.
- R4: Accepting a token advances the pointer by one and wraps from the last queue to queue 0, so bit k of out_valid selects queue k.
- R5: Beats with in_last=0 are continuations of one item. All beats of an item go to the same queue, and only the beat with in_last=1 counts toward the batch.
- R6: When the selected queue is not ready, in_ready is 0 and no other queue is offered anything. A pending token holds steady until that queue accepts it.
- R7: The batch size comes from batch_size at the moment each item completes. A value of 0 acts as 1, and a size of 2 is supported.
- R8: A pulse on flush, taken at the next item boundary, issues a token after a partial batch and clears the count. When the batch is empty, a flush does nothing. When it arrives in the middle of an item, it waits for that item's last beat.
- R9: At most one bit of out_valid is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batch_size | input | CNT_W | Number of items per batch (0 acts as 1) |
| flush | input | 1 | Single-cycle request to close the current partial batch |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | DATA_W | Input payload |
| in_last | input | 1 | Marks the final beat of an item |
| out_valid | output | N_UNITS | One-hot valid, one bit per downstream queue |
| out_ready | input | N_UNITS | Ready from each downstream queue |
| out_data | output | DATA_W | Shared payload; zero on token beats |
| out_tok | output | 1 | High on a token beat |

## Verification
The bench first drives a sequence of single-beat and two-beat items across a full rotation and back to queue 0. A design that counted continuation beats, or that failed to wrap the pointer, would route an item to the wrong queue. It then holds one queue's ready low, both while a data beat waits and while a token waits. A design that skipped ahead to another queue, or dropped a stalled token, would show a wrong valid bit or a missing token. Flush is applied after a partial batch, on an empty batch, and in the middle of a two-beat item; a wrong design would emit stray tokens or cut the item in two. Finally, a batch size of 0 is tried, and reset is applied in the middle of a batch to confirm that the rotation restarts at queue 0.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  typedef enum logic {
    ST_SEND  = 1'b0,
    ST_TOKEN = 1'b1
  } rbd_state_e;

endpackage

// File: rtl/rbd_unit_ptr.sv
module rbd_unit_ptr #(
  parameter int N_UNITS = 4,
  localparam int PTR_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(N_UNITS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (adv_i) begin
      if (ptr_q == LAST_IDX) ptr_n = '0;
      else                   ptr_n = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_n;
  end

  assign ptr_o = ptr_q;

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : ($past(ptr_q) + PTR_W'(1))));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(ptr_q));

endmodule

// File: rtl/rbd_batch_count.sv
module rbd_batch_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             item_done_i,
  input  logic [CNT_W-1:0] size_i,
  output logic             full_o,
  output logic             empty_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W:0]   eff_size;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_en;

  always_comb begin
    eff_size = (size_i == '0) ? (CNT_W+1)'(1) : {1'b0, size_i};
    cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    full_o   = item_done_i && (cnt_inc >= eff_size);
    empty_o  = (cnt_q == '0);
    cnt_en   = clr_i || item_done_i;
    if (clr_i) cnt_n = '0;
    else       cnt_n = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/rbd_seq_ctrl.sv
module rbd_seq_ctrl
  import rbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid_i,
  input  logic in_last_i,
  input  logic flush_i,
  input  logic sel_ready_i,
  input  logic batch_full_i,
  input  logic batch_empty_i,
  output logic in_ready_o,
  output logic sel_valid_o,
  output logic tok_o,
  output logic item_done_o,
  output logic adv_o
);

  rbd_state_e state_q, state_n;
  logic       mid_q, mid_n;
  logic       pend_q, pend_n;
  logic       boundary_hold;
  logic       send_ok;
  logic       fire;
  logic       tok_fire;
  logic       drop_flush;

  always_comb begin
    boundary_hold = pend_q && !mid_q;
    send_ok       = (state_q == ST_SEND) && !boundary_hold;
    in_ready_o    = send_ok && sel_ready_i;
    fire          = in_valid_i && in_ready_o;
    item_done_o   = fire && in_last_i;
    tok_o         = (state_q == ST_TOKEN);
    tok_fire      = tok_o && sel_ready_i;
    adv_o         = tok_fire;
    sel_valid_o   = tok_o || (send_ok && in_valid_i);
    drop_flush    = (state_q == ST_SEND) && boundary_hold && batch_empty_i;
  end

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_SEND: begin
        if (item_done_o && batch_full_i)        state_n = ST_TOKEN;
        else if (boundary_hold && !batch_empty_i) state_n = ST_TOKEN;
      end
      ST_TOKEN: begin
        if (tok_fire) state_n = ST_SEND;
      end
      default: state_n = ST_SEND;
    endcase
    mid_n  = fire ? !in_last_i : mid_q;
    pend_n = (tok_fire || drop_flush) ? flush_i : (pend_q || flush_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEND;
      mid_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (fire) mid_q <= mid_n;
      pend_q  <= pend_n;
    end
  end

  // R5
  mid_no_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_q |-> !tok_o);

  // R3
  tok_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done_o && batch_full_i) |=> tok_o);

endmodule

// File: rtl/rr_batch_dist.sv
module rr_batch_dist #(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   batch_size,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_last,
  output logic [N_UNITS-1:0] out_valid,
  input  logic [N_UNITS-1:0] out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_tok
);

  localparam int PTR_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

  logic [PTR_W-1:0] ptr;
  logic             sel_ready;
  logic             sel_valid;
  logic             tok;
  logic             item_done;
  logic             adv;
  logic             batch_full;
  logic             batch_empty;

  rbd_unit_ptr #(.N_UNITS(N_UNITS)) ptr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv),
    .ptr_o (ptr)
  );

  rbd_batch_count #(.CNT_W(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (adv),
    .item_done_i (item_done),
    .size_i      (batch_size),
    .full_o      (batch_full),
    .empty_o     (batch_empty)
  );

  rbd_seq_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid_i    (in_valid),
    .in_last_i     (in_last),
    .flush_i       (flush),
    .sel_ready_i   (sel_ready),
    .batch_full_i  (batch_full),
    .batch_empty_i (batch_empty),
    .in_ready_o    (in_ready),
    .sel_valid_o   (sel_valid),
    .tok_o         (tok),
    .item_done_o   (item_done),
    .adv_o         (adv)
  );

  assign sel_ready = out_ready[ptr];

  for (genvar k = 0; k < N_UNITS; k++) begin : g_lane
    assign out_valid[k] = sel_valid && (ptr == PTR_W'(k));
  end

  assign out_data = tok ? '0 : in_data;
  assign out_tok  = tok;

  // R9
  onehot_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  // R3
  tok_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tok |-> !in_ready);

  // R6
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tok && ((out_valid & out_ready) == '0)) |=> (out_tok && $stable(out_valid)));

endmodule

// File: tb/rr_batch_dist_tb_top.sv
`timescale 1ns/1ps
module rr_batch_dist_tb_top;

  localparam int N  = 4;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] batch_size;
  logic          flush;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          in_last;
  logic [N-1:0]  out_valid;
  logic [N-1:0]  out_ready;
  logic [DW-1:0] out_data;
  logic          out_tok;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rr_batch_dist #(.N_UNITS(N), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .batch_size(batch_size), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_tok(out_tok)
  );

  // {tok_after, port[1:0], last, data[15:0]} with batch size 2
  localparam logic [19:0] VEC [11] = '{
    {1'b0, 2'd0, 1'b1, 16'h1111},
    {1'b1, 2'd0, 1'b1, 16'h2222},
    {1'b0, 2'd1, 1'b0, 16'h3331},
    {1'b0, 2'd1, 1'b1, 16'h3332},
    {1'b1, 2'd1, 1'b1, 16'h4444},
    {1'b0, 2'd2, 1'b1, 16'h5555},
    {1'b1, 2'd2, 1'b1, 16'h6666},
    {1'b0, 2'd3, 1'b1, 16'h7777},
    {1'b1, 2'd3, 1'b1, 16'h8888},
    {1'b0, 2'd0, 1'b0, 16'h9991},
    {1'b0, 2'd0, 1'b1, 16'h9992}
  };

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_beat(input logic [DW-1:0] d, input logic l, input int port, input string req);
    int w;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l;
    #1;
    w = 0;
    while (!in_ready && w < 8) begin
      @(negedge clk); #1; w++;
    end
    chk(in_ready == 1'b1, req, "in_ready", 32'(in_ready), 32'd1);
    chk(out_valid == N'(1 << port) && out_data == d && !out_tok, req, "data beat valid",
        32'(out_valid), 32'(1 << port));
    @(posedge clk);
  endtask

  task automatic expect_tok(input int port, input int maxw, input string req);
    int w;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    w = 0;
    while (!out_tok && w < maxw) begin
      @(negedge clk); #1; w++;
    end
    chk(out_tok && out_valid == N'(1 << port) && out_data == '0 && !in_ready, req,
        "token beat valid", 32'(out_valid), 32'(1 << port));
    @(posedge clk);
  endtask

  task automatic pulse_flush();
    @(negedge clk); in_valid = 1'b0; flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    rst_n = 1'b0; batch_size = CW'(2); flush = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b1; out_ready = '1;
    repeat (3) @(negedge clk);
    #1;
    // R1 outputs idle during reset
    chk(out_valid == '0 && !out_tok, "R1", "idle in reset", 32'(out_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(out_valid == '0 && !out_tok, "R1", "idle after reset", 32'(out_valid), 32'd0);

    // R2 R3 R4 R5 table walk: first item lands on queue 0 (R1)
    foreach (VEC[i]) begin
      do_beat(VEC[i][15:0], VEC[i][16], int'(VEC[i][18:17]), (i == 0) ? "R1" : "R2/R5");
      if (VEC[i][19]) expect_tok(int'(VEC[i][18:17]), 0, "R3/R4");
    end

    // R6 stall on data beat: queue 0 holds one item already
    @(negedge clk);
    out_ready = 4'b1110; in_valid = 1'b1; in_data = 16'hAAAA; in_last = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(!in_ready && out_valid == 4'b0001, "R6", "data stall", 32'(out_valid), 32'd1);
      @(negedge clk);
    end
    out_ready = '1;
    #1;
    chk(in_ready && out_valid == 4'b0001, "R6", "stall release", 32'(in_ready), 32'd1);
    @(posedge clk);
    // R6 stall on token
    @(negedge clk);
    in_valid = 1'b0; out_ready = 4'b1110;
    #1;
    chk(out_tok && out_valid == 4'b0001, "R6", "token shown", 32'(out_valid), 32'd1);
    @(negedge clk); #1;
    chk(out_tok && out_valid == 4'b0001 && !in_ready, "R6", "token held", 32'(out_valid), 32'd1);
    out_ready = '1;
    @(posedge clk);

    // R8 flush after partial batch on queue 1
    do_beat(16'hB001, 1'b1, 1, "R4");
    pulse_flush();
    expect_tok(1, 3, "R8");
    // R8 flush with empty batch: no token, pointer stays on queue 2
    pulse_flush();
    do_beat(16'hC001, 1'b1, 2, "R8");
    @(negedge clk); in_valid = 1'b0; #1;
    chk(!out_tok && out_valid == '0, "R8", "no token after one item", 32'(out_tok), 32'd0);
    pulse_flush();
    expect_tok(2, 3, "R8");

    // R8 R5 flush in mid item, batch size 3
    batch_size = CW'(3);
    @(negedge clk); flush = 1'b1; in_valid = 1'b1; in_data = 16'hD001; in_last = 1'b0;
    #1;
    chk(in_ready && out_valid == 4'b1000, "R5", "first beat", 32'(out_valid), 32'h8);
    @(posedge clk);
    @(negedge clk); flush = 1'b0;
    do_beat(16'hD002, 1'b1, 3, "R8");
    expect_tok(3, 3, "R8");

    // R7 batch size 0 acts as 1
    batch_size = '0;
    do_beat(16'hE001, 1'b1, 0, "R7");
    expect_tok(0, 0, "R7");
    do_beat(16'hE002, 1'b1, 1, "R7");
    expect_tok(1, 0, "R7");

    // R1 reset in mid batch restarts at queue 0
    batch_size = CW'(2);
    do_beat(16'hF001, 1'b1, 2, "R4");
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0; #1;
    chk(out_valid == '0 && !out_tok, "R1", "reset mid batch", 32'(out_valid), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    do_beat(16'hF002, 1'b1, 0, "R1");
    @(negedge clk); in_valid = 1'b0; #1;
    chk(!out_tok, "R1", "count cleared by reset", 32'(out_tok), 32'd0);

    report();
  end

endmodule